// File: doc/BRIEF.md
# Barrel Multithreaded Integer Core

This block is a compact 32-bit integer processor for the base integer instruction set. It holds several hardware threads, eight by default, and runs them through one shared five-stage in-order pipeline. Each thread owns a program counter and a 32-entry register file. The pipeline stages are fetch, decode, execute, memory and writeback. Issue rotates through the threads in a fixed order, one instruction per clock. A thread therefore comes back to fetch only after its previous instruction has left writeback. Because of this, the core has no hazard detection, no forwarding, no stall logic and no branch prediction.

The core is meant to sit next to accelerator datapaths as a small programmable controller. Each thread gets a start address at reset. Instructions come from a synchronous instruction port: the address is presented in fetch and the word is consumed one cycle later in decode. Loads and stores use a synchronous data port with byte enables: the request is made in the memory stage and read data is consumed in writeback. System, fence and unknown opcodes retire as no-operations.

Top module: `barrel_core`

## Requirements
- R1: In the k-th clock after reset is released, the fetch address belongs to thread k mod 8. During the first eight clocks the fetch addresses are exactly the eight start addresses, taken from `start_pc_i` slice t (bits 32t+31 down to 32t).
- R2: A thread's program counter is updated once per rotation, eight clocks apart. Without a control transfer it advances by 4, so the second rotation fetches each start address plus 4.
- R3: Register x0 reads as zero in every thread, and any write to it is discarded.
- R4: Each thread's registers are private. A result written by one instruction is seen by the same thread's next instruction with no stall. Two threads writing the same register number never disturb each other.
- R5: Register and immediate arithmetic, logic, shift and compare instructions produce results per the base integer set. This covers add, sub, xor, shifts by immediate, slt and sltu. The upper-immediate instructions also follow the base set: lui loads the immediate, and auipc adds the immediate to the program counter.
- R6: Control transfer. A taken conditional branch skips to pc+offset. A not-taken branch falls through. jal and jalr jump and write pc+4 into rd, and jalr clears bit 0 of its target.
- R7: Stores drive the word-aligned address and byte enables taken from address bits [1:0]. A byte store enables lane addr[1:0]. A halfword store enables lanes 1:0 (0011) or 3:2 (1100) by addr[1]. A word store enables all four lanes (1111). lb and lh sign-extend; lbu and lhu zero-extend.
- R8: While `rst_n` is low, every register is cleared, every program counter loads its start address, and no data request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pc_i | input | 256 | Start address per thread, thread t in bits 32t+31:32t |
| imem_addr_o | output | 32 | Instruction fetch address |
| imem_rdata_i | input | 32 | Instruction word, one cycle after its address |
| dmem_req_o | output | 1 | Data access request (load or store) |
| dmem_we_o | output | 1 | Data access is a store |
| dmem_be_o | output | 4 | Byte lane enables |
| dmem_addr_o | output | 32 | Word-aligned data address |
| dmem_wdata_o | output | 32 | Store data, replicated across lanes |
| dmem_rdata_i | input | 32 | Load data, one cycle after the request |

## Verification
In a single clock, writeback can update one thread's register file while decode reads the same register number for another thread. In that same clock, execute can also write a program counter while fetch reads a different one. The bench provokes both by having all eight threads run the same program on the same register numbers, each with its own values. Any crossing of results or of program counters then shows up as a wrong value or a wrong address in the stream of stores that the scoreboard compares per thread.

// File: rtl/barrel_pkg.sv
// Package: shared types and opcodes for the barrel core.
// Assumes the 32-bit base integer instruction set; the data width is fixed by it.
package barrel_pkg;

    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] { OPA_RS1, OPA_PC, OPA_ZERO } opa_e;
    typedef enum logic       { OPB_RS2, OPB_IMM } opb_e;
    typedef enum logic [1:0] { FLOW_SEQ, FLOW_BRANCH, FLOW_JAL, FLOW_JALR } flow_e;

    typedef struct packed {
        alu_op_e     alu_op;
        opa_e        opa;
        opb_e        opb;
        flow_e       flow;
        logic        rd_wen;
        logic        link;
        logic        is_load;
        logic        is_store;
        logic [2:0]  funct3;
    } ctl_t;

    localparam ctl_t CTL_NOP = '{alu_op: ALU_ADD, opa: OPA_RS1, opb: OPB_RS2,
                                 flow: FLOW_SEQ, rd_wen: 1'b0, link: 1'b0,
                                 is_load: 1'b0, is_store: 1'b0, funct3: 3'b000};

endpackage

// File: rtl/barrel_decode.sv
// Module: barrel_decode
// Turns one instruction word into a control bundle, register indices and the
// sign-extended immediate. Purely combinational. Opcodes outside the supported
// integer set decode to a no-operation that writes nothing.
module barrel_decode
    import barrel_pkg::*;
(
    input  logic [XLEN-1:0]   instr_i,
    output ctl_t              ctl_o,
    output logic [REG_AW-1:0] rs1_o,
    output logic [REG_AW-1:0] rs2_o,
    output logic [REG_AW-1:0] rd_o,
    output logic [XLEN-1:0]   imm_o
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic       alt;

    assign opcode = instr_i[6:0];
    assign funct3 = instr_i[14:12];
    assign alt    = instr_i[30];
    assign rd_o   = instr_i[11:7];
    assign rs1_o  = instr_i[19:15];
    assign rs2_o  = instr_i[24:20];

    // Maps a funct3 code and the alternate bit onto an ALU operation.
    function automatic alu_op_e pick_op(input logic [2:0] f3, input logic alt_b);
        case (f3)
            3'b000:  pick_op = alt_b ? ALU_SUB : ALU_ADD;
            3'b001:  pick_op = ALU_SLL;
            3'b010:  pick_op = ALU_SLT;
            3'b011:  pick_op = ALU_SLTU;
            3'b100:  pick_op = ALU_XOR;
            3'b101:  pick_op = alt_b ? ALU_SRA : ALU_SRL;
            3'b110:  pick_op = ALU_OR;
            default: pick_op = ALU_AND;
        endcase
    endfunction

    // Builds the control bundle and the immediate for each opcode class.
    always_comb begin
        ctl_o        = CTL_NOP;
        ctl_o.funct3 = funct3;
        imm_o        = '0;
        case (opcode)
            OPC_LUI: begin
                ctl_o.opa    = OPA_ZERO;
                ctl_o.opb    = OPB_IMM;
                ctl_o.rd_wen = 1'b1;
                imm_o        = {instr_i[31:12], 12'b0};
            end
            OPC_AUIPC: begin
                ctl_o.opa    = OPA_PC;
                ctl_o.opb    = OPB_IMM;
                ctl_o.rd_wen = 1'b1;
                imm_o        = {instr_i[31:12], 12'b0};
            end
            OPC_JAL: begin
                ctl_o.flow   = FLOW_JAL;
                ctl_o.link   = 1'b1;
                ctl_o.rd_wen = 1'b1;
                imm_o        = {{12{instr_i[31]}}, instr_i[19:12], instr_i[20],
                                instr_i[30:21], 1'b0};
            end
            OPC_JALR: begin
                ctl_o.flow   = FLOW_JALR;
                ctl_o.link   = 1'b1;
                ctl_o.rd_wen = 1'b1;
                imm_o        = {{20{instr_i[31]}}, instr_i[31:20]};
            end
            OPC_BRANCH: begin
                ctl_o.flow   = FLOW_BRANCH;
                imm_o        = {{20{instr_i[31]}}, instr_i[7], instr_i[30:25],
                                instr_i[11:8], 1'b0};
            end
            OPC_LOAD: begin
                ctl_o.is_load = 1'b1;
                ctl_o.rd_wen  = 1'b1;
                ctl_o.opb     = OPB_IMM;
                imm_o         = {{20{instr_i[31]}}, instr_i[31:20]};
            end
            OPC_STORE: begin
                ctl_o.is_store = 1'b1;
                ctl_o.opb      = OPB_IMM;
                imm_o          = {{20{instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
            end
            OPC_OPIMM: begin
                ctl_o.rd_wen = 1'b1;
                ctl_o.opb    = OPB_IMM;
                ctl_o.alu_op = pick_op(funct3, alt && (funct3 == 3'b101));
                imm_o        = {{20{instr_i[31]}}, instr_i[31:20]};
            end
            OPC_OP: begin
                ctl_o.rd_wen = 1'b1;
                ctl_o.alu_op = pick_op(funct3, alt);
            end
            default: ctl_o = CTL_NOP;
        endcase
    end

endmodule

// File: rtl/barrel_alu.sv
// Module: barrel_alu
// Integer ALU plus the conditional-branch comparator. Combinational.
// Assumes shift amounts come from the low five bits of operand b.
module barrel_alu
    import barrel_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    input  logic [2:0]       cmp_sel_i,
    input  logic [XLEN-1:0]  cmp_a_i,
    input  logic [XLEN-1:0]  cmp_b_i,
    output logic [XLEN-1:0]  y_o,
    output logic             take_o
);

    logic [4:0] shamt;
    assign shamt = b_i[4:0];

    // Computes the arithmetic or logic result.
    always_comb begin
        case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_SLL:  y_o = a_i << shamt;
            ALU_SLT:  y_o = {31'b0, $signed(a_i) < $signed(b_i)};
            ALU_SLTU: y_o = {31'b0, a_i < b_i};
            ALU_XOR:  y_o = a_i ^ b_i;
            ALU_SRL:  y_o = a_i >> shamt;
            ALU_SRA:  y_o = $unsigned($signed(a_i) >>> shamt);
            ALU_OR:   y_o = a_i | b_i;
            default:  y_o = a_i & b_i;
        endcase
    end

    // Decides whether a conditional branch is taken.
    always_comb begin
        case (cmp_sel_i)
            3'b000:  take_o = (cmp_a_i == cmp_b_i);
            3'b001:  take_o = (cmp_a_i != cmp_b_i);
            3'b100:  take_o = ($signed(cmp_a_i) <  $signed(cmp_b_i));
            3'b101:  take_o = ($signed(cmp_a_i) >= $signed(cmp_b_i));
            3'b110:  take_o = (cmp_a_i <  cmp_b_i);
            3'b111:  take_o = (cmp_a_i >= cmp_b_i);
            default: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/barrel_lsu.sv
// Module: barrel_lsu
// Lane logic for the data port: byte enables and replicated store data on the
// request side, lane selection and extension on the return side.
// Assumes naturally aligned accesses; misalignment is not detected.
module barrel_lsu
    import barrel_pkg::*;
(
    input  logic [2:0]       st_size_i,
    input  logic [1:0]       st_off_i,
    input  logic [XLEN-1:0]  st_data_i,
    output logic [3:0]       st_be_o,
    output logic [XLEN-1:0]  st_wdata_o,
    input  logic [2:0]       ld_kind_i,
    input  logic [1:0]       ld_off_i,
    input  logic [XLEN-1:0]  ld_rdata_i,
    output logic [XLEN-1:0]  ld_value_o
);

    logic [7:0]  ld_byte;
    logic [15:0] ld_half;

    // Forms lane enables and lane-replicated data for a request.
    always_comb begin
        case (st_size_i[1:0])
            2'b00: begin
                st_be_o    = 4'b0001 << st_off_i;
                st_wdata_o = {4{st_data_i[7:0]}};
            end
            2'b01: begin
                st_be_o    = st_off_i[1] ? 4'b1100 : 4'b0011;
                st_wdata_o = {2{st_data_i[15:0]}};
            end
            default: begin
                st_be_o    = 4'b1111;
                st_wdata_o = st_data_i;
            end
        endcase
    end

    assign ld_byte = ld_rdata_i[8*ld_off_i +: 8];
    assign ld_half = ld_off_i[1] ? ld_rdata_i[31:16] : ld_rdata_i[15:0];

    // Selects the addressed lanes of returned data and extends them.
    always_comb begin
        case (ld_kind_i)
            3'b000:  ld_value_o = {{24{ld_byte[7]}}, ld_byte};
            3'b001:  ld_value_o = {{16{ld_half[15]}}, ld_half};
            3'b100:  ld_value_o = {24'b0, ld_byte};
            3'b101:  ld_value_o = {16'b0, ld_half};
            default: ld_value_o = ld_rdata_i;
        endcase
    end

endmodule

// File: rtl/barrel_regfile.sv
// Module: barrel_regfile
// One 32-entry register bank per thread, held in a single array indexed by
// {thread, register}. Two asynchronous read ports for one thread and one
// write port for another. Register 0 of every bank reads zero and ignores writes.
// Assumes the caller never reads and writes the same thread in one cycle.
module barrel_regfile
    import barrel_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int DEPTH      = NUM_THREADS << REG_AW
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TID_W-1:0]  rd_tid_i,
    input  logic [REG_AW-1:0] ra1_i,
    input  logic [REG_AW-1:0] ra2_i,
    output logic [XLEN-1:0]   rd1_o,
    output logic [XLEN-1:0]   rd2_o,
    input  logic              we_i,
    input  logic [TID_W-1:0]  wr_tid_i,
    input  logic [REG_AW-1:0] wa_i,
    input  logic [XLEN-1:0]   wd_i
);

    logic [XLEN-1:0] regs [DEPTH];

    // Clears all banks on reset, otherwise writes one non-zero register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we_i && (wa_i != '0)) begin
            regs[{wr_tid_i, wa_i}] <= wd_i;
        end
    end

    assign rd1_o = (ra1_i == '0) ? '0 : regs[{rd_tid_i, ra1_i}];
    assign rd2_o = (ra2_i == '0) ? '0 : regs[{rd_tid_i, ra2_i}];

endmodule

// File: rtl/barrel_core.sv
// Module: barrel_core
// Five-stage barrel pipeline (fetch, decode, execute, memory, writeback).
// A thread counter selects one program counter per clock in fixed rotation.
// The thread tag rides with each instruction so that execute updates the right
// program counter and writeback the right register bank.
// Assumes NUM_THREADS is a power of two no smaller than the five stages, and
// instruction and data memories that answer one cycle after the request.
module barrel_core
    import barrel_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    localparam int TID_W      = $clog2(NUM_THREADS)
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS*XLEN-1:0] start_pc_i,
    output logic [XLEN-1:0]             imem_addr_o,
    input  logic [XLEN-1:0]             imem_rdata_i,
    output logic                        dmem_req_o,
    output logic                        dmem_we_o,
    output logic [3:0]                  dmem_be_o,
    output logic [XLEN-1:0]             dmem_addr_o,
    output logic [XLEN-1:0]             dmem_wdata_o,
    input  logic [XLEN-1:0]             dmem_rdata_i
);

    // ---------------- fetch ----------------
    logic [TID_W-1:0] f_tid;
    logic [XLEN-1:0]  pc_q [NUM_THREADS];
    logic             pc_we;
    logic [XLEN-1:0]  pc_next;

    // Steps the issue slot to the next thread every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) f_tid <= '0;
        else        f_tid <= f_tid + 1'b1;
    end

    // One program counter per thread, loaded at reset, rewritten by execute.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
        always_ff @(posedge clk) begin
            if (!rst_n)
                pc_q[t] <= start_pc_i[t*XLEN +: XLEN];
            else if (pc_we && (e_tid == TID_W'(t)))
                pc_q[t] <= pc_next;
        end
    end

    assign imem_addr_o = pc_q[f_tid];

    // ---------------- decode ----------------
    logic             d_vld;
    logic [TID_W-1:0] d_tid;
    logic [XLEN-1:0]  d_pc;
    ctl_t             d_ctl;
    logic [REG_AW-1:0] d_rs1, d_rs2, d_rd;
    logic [XLEN-1:0]  d_imm, d_rs1v, d_rs2v;

    // Carries the fetched thread and its address into decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_vld <= 1'b0;
            d_tid <= '0;
            d_pc  <= '0;
        end else begin
            d_vld <= 1'b1;
            d_tid <= f_tid;
            d_pc  <= imem_addr_o;
        end
    end

    barrel_decode u_dec (
        .instr_i (imem_rdata_i),
        .ctl_o   (d_ctl),
        .rs1_o   (d_rs1),
        .rs2_o   (d_rs2),
        .rd_o    (d_rd),
        .imm_o   (d_imm)
    );

    logic             w_we;
    logic [TID_W-1:0] w_tid;
    logic [REG_AW-1:0] w_rd;
    logic [XLEN-1:0]  w_data;

    barrel_regfile #(.NUM_THREADS(NUM_THREADS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_tid_i (d_tid),
        .ra1_i    (d_rs1),
        .ra2_i    (d_rs2),
        .rd1_o    (d_rs1v),
        .rd2_o    (d_rs2v),
        .we_i     (w_we),
        .wr_tid_i (w_tid),
        .wa_i     (w_rd),
        .wd_i     (w_data)
    );

    // ---------------- execute ----------------
    logic             e_vld;
    logic [TID_W-1:0] e_tid;
    logic [XLEN-1:0]  e_pc, e_imm, e_rs1v, e_rs2v;
    ctl_t             e_ctl;
    logic [REG_AW-1:0] e_rd;

    // Registers decoded control and operands into execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld  <= 1'b0;
            e_tid  <= '0;
            e_pc   <= '0;
            e_imm  <= '0;
            e_rs1v <= '0;
            e_rs2v <= '0;
            e_ctl  <= CTL_NOP;
            e_rd   <= '0;
        end else begin
            e_vld  <= d_vld;
            e_tid  <= d_tid;
            e_pc   <= d_pc;
            e_imm  <= d_imm;
            e_rs1v <= d_rs1v;
            e_rs2v <= d_rs2v;
            e_ctl  <= d_ctl;
            e_rd   <= d_rd;
        end
    end

    logic [XLEN-1:0] alu_a, alu_b, alu_y, pc_plus4, tgt_base, target, e_result;
    logic            take, redirect;
    logic [3:0]      e_be;
    logic [XLEN-1:0] e_wdata;

    // Selects the ALU operands from registers, program counter or immediate.
    always_comb begin
        case (e_ctl.opa)
            OPA_PC:   alu_a = e_pc;
            OPA_ZERO: alu_a = '0;
            default:  alu_a = e_rs1v;
        endcase
        alu_b = (e_ctl.opb == OPB_IMM) ? e_imm : e_rs2v;
    end

    barrel_alu u_alu (
        .op_i      (e_ctl.alu_op),
        .a_i       (alu_a),
        .b_i       (alu_b),
        .cmp_sel_i (e_ctl.funct3),
        .cmp_a_i   (e_rs1v),
        .cmp_b_i   (e_rs2v),
        .y_o       (alu_y),
        .take_o    (take)
    );

    // Resolves the thread's next program counter and the link value.
    always_comb begin
        pc_plus4 = e_pc + 32'd4;
        tgt_base = (e_ctl.flow == FLOW_JALR) ? e_rs1v : e_pc;
        target   = tgt_base + e_imm;
        if (e_ctl.flow == FLOW_JALR) target[0] = 1'b0;
        redirect = (e_ctl.flow == FLOW_JAL) || (e_ctl.flow == FLOW_JALR) ||
                   ((e_ctl.flow == FLOW_BRANCH) && take);
        pc_next  = redirect ? target : pc_plus4;
        e_result = e_ctl.link ? pc_plus4 : alu_y;
    end

    assign pc_we = e_vld;

    // ---------------- memory ----------------
    logic             m_vld, m_wen, m_load, m_store;
    logic [TID_W-1:0] m_tid;
    logic [REG_AW-1:0] m_rd;
    logic [XLEN-1:0]  m_result, m_wdata;
    logic [2:0]       m_f3;
    logic [3:0]       m_be;

    // Moves the execute result and any data access into the memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_vld    <= 1'b0;
            m_wen    <= 1'b0;
            m_load   <= 1'b0;
            m_store  <= 1'b0;
            m_tid    <= '0;
            m_rd     <= '0;
            m_result <= '0;
            m_wdata  <= '0;
            m_f3     <= '0;
            m_be     <= '0;
        end else begin
            m_vld    <= e_vld;
            m_wen    <= e_ctl.rd_wen;
            m_load   <= e_ctl.is_load;
            m_store  <= e_ctl.is_store;
            m_tid    <= e_tid;
            m_rd     <= e_rd;
            m_result <= e_result;
            m_wdata  <= e_wdata;
            m_f3     <= e_ctl.funct3;
            m_be     <= e_be;
        end
    end

    assign dmem_req_o   = m_vld && (m_load || m_store);
    assign dmem_we_o    = m_vld && m_store;
    assign dmem_be_o    = m_be;
    assign dmem_addr_o  = {m_result[XLEN-1:2], 2'b00};
    assign dmem_wdata_o = m_wdata;

    // ---------------- writeback ----------------
    logic             w_vld, w_wen, w_load;
    logic [XLEN-1:0]  w_result, w_ldv;
    logic [2:0]       w_f3;
    logic [1:0]       w_off;

    // Moves the result into writeback, where load data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vld    <= 1'b0;
            w_wen    <= 1'b0;
            w_load   <= 1'b0;
            w_tid    <= '0;
            w_rd     <= '0;
            w_result <= '0;
            w_f3     <= '0;
            w_off    <= '0;
        end else begin
            w_vld    <= m_vld;
            w_wen    <= m_wen;
            w_load   <= m_load;
            w_tid    <= m_tid;
            w_rd     <= m_rd;
            w_result <= m_result;
            w_f3     <= m_f3;
            w_off    <= m_result[1:0];
        end
    end

    barrel_lsu u_lsu (
        .st_size_i  (e_ctl.funct3),
        .st_off_i   (alu_y[1:0]),
        .st_data_i  (e_rs2v),
        .st_be_o    (e_be),
        .st_wdata_o (e_wdata),
        .ld_kind_i  (w_f3),
        .ld_off_i   (w_off),
        .ld_rdata_i (dmem_rdata_i),
        .ld_value_o (w_ldv)
    );

    assign w_we   = w_vld && w_wen;
    assign w_data = w_load ? w_ldv : w_result;

endmodule

// File: rtl/barrel_core_chk.sv
// Module: barrel_core_chk
// Property checker bound into barrel_core. Observes the thread tags of the
// stages, the register read path and the data port.
module barrel_core_chk #(
    parameter int NUM_THREADS = 8,
    localparam int TID_W      = $clog2(NUM_THREADS)
)(
    input logic             clk,
    input logic             rst_n,
    input logic [TID_W-1:0] f_tid,
    input logic             d_vld,
    input logic [TID_W-1:0] d_tid,
    input logic             w_vld,
    input logic [TID_W-1:0] w_tid,
    input logic             pc_we,
    input logic [TID_W-1:0] e_tid,
    input logic [4:0]       rs1_addr,
    input logic [31:0]      rs1_data,
    input logic             dmem_req,
    input logic [3:0]       dmem_be
);

    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        d_vld |-> (d_tid == TID_W'(f_tid - 1'b1))); // R1

    AST_PC_NOT_FETCHING: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (e_tid != f_tid)); // R2

    AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == 5'd0) |-> (rs1_data == 32'd0)); // R3

    AST_WB_TID: assert property (@(posedge clk) disable iff (!rst_n)
        w_vld |-> (w_tid == TID_W'(f_tid - 3'd4))); // R4

    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req |-> ($countones(dmem_be) inside {1, 2, 4})); // R7

    // Checks that no data request leaves the core while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_NO_REQ_IN_RESET: assert (!dmem_req); // R8
        end
    end

endmodule

bind barrel_core barrel_core_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .f_tid    (f_tid),
    .d_vld    (d_vld),
    .d_tid    (d_tid),
    .w_vld    (w_vld),
    .w_tid    (w_tid),
    .pc_we    (pc_we),
    .e_tid    (e_tid),
    .rs1_addr (d_rs1),
    .rs1_data (d_rs1v),
    .dmem_req (dmem_req_o),
    .dmem_be  (dmem_be_o)
);

// File: tb/barrel_core_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: every thread runs the same program on its own values.
// The driver pushes the expected stores per thread and the monitor pops them.
module barrel_core_bench;

    localparam int NT = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT*32-1:0] start_pc;
    logic [31:0]     imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic            dmem_req, dmem_we;
    logic [3:0]      dmem_be;

    always #10 clk = ~clk;

    barrel_core u_barrel_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_pc_i   (start_pc),
        .imem_addr_o  (imem_addr),
        .imem_rdata_i (imem_rdata),
        .dmem_req_o   (dmem_req),
        .dmem_we_o    (dmem_we),
        .dmem_be_o    (dmem_be),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .dmem_rdata_i (dmem_rdata)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       req;
    } st_item_t;

    st_item_t    exp_q [NT][$];
    logic [31:0] imem [512];
    logic [31:0] dmem [256];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          ptr;
    bit          done = 1'b0;

    // Synchronous instruction memory.
    always @(posedge clk) imem_rdata <= imem[imem_addr[10:2]];

    // Synchronous data memory with lane enables.
    always @(posedge clk) begin
        if (dmem_req && dmem_we) begin
            for (int b = 0; b < 4; b++)
                if (dmem_be[b]) dmem[dmem_addr[9:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
        end else if (dmem_req) begin
            dmem_rdata <= dmem[dmem_addr[9:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: each store is compared with the head of its thread's queue.
    always @(negedge clk) begin
        if (rst_n && dmem_req && dmem_we) begin
            automatic int        tid = int'(dmem_addr[9:7]);
            automatic st_item_t  it;
            automatic logic [31:0] mask;
            if (exp_q[tid].size() == 0) begin
                check("R6 unexpected store", dmem_addr, 32'hFFFF_FFFF);
            end else begin
                it   = exp_q[tid].pop_front();
                mask = {{8{it.be[3]}}, {8{it.be[2]}}, {8{it.be[1]}}, {8{it.be[0]}}};
                check({it.req, " addr"}, dmem_addr, it.addr);
                check({it.req, " be"}, {28'b0, dmem_be}, {28'b0, it.be});
                check({it.req, " data"}, dmem_wdata & mask, it.data & mask);
            end
        end
    end

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
    endfunction

    task automatic put(input int t, input logic [31:0] ins);
        imem[t*64 + ptr] = ins;
        ptr++;
    endtask

    task automatic expect_st(input int t, input int off, input logic [31:0] data,
                             input logic [3:0] be, input string req);
        st_item_t it;
        it.addr = 32'h1000 + t*128 + off;
        it.data = data;
        it.be   = be;
        it.req  = req;
        exp_q[t].push_back(it);
    endtask

    // Driver: writes one thread's program and queues the stores it must make.
    task automatic build_thread(input int t);
        logic [31:0] x1, x3, pcv;
        int o;
        ptr = 0;
        o   = t & 3;
        x1  = 32'(100 + t);
        x3  = 32'hFFFF_FFFD;
        put(t, {20'h00001, 5'd2, 7'b0110111});                     // lui x2
        put(t, enc_i(12'(t*128), 5'd2, 3'b000, 5'd2, 7'b0010011)); // base
        put(t, enc_s(12'd0, 5'd5, 5'd2, 3'b010));
        expect_st(t, 0, 32'd0, 4'hF, "R8 reset-cleared register");
        put(t, enc_i(12'(100 + t), 5'd0, 3'b000, 5'd1, 7'b0010011));
        put(t, enc_i(12'd7, 5'd0, 3'b000, 5'd0, 7'b0010011));     // write x0
        put(t, enc_s(12'd4, 5'd0, 5'd2, 3'b010));
        expect_st(t, 4, 32'd0, 4'hF, "R3 x0 stays zero");
        put(t, enc_s(12'd8, 5'd1, 5'd2, 3'b010));
        expect_st(t, 8, x1, 4'hF, "R4 private register");
        put(t, enc_i(12'hFFD, 5'd0, 3'b000, 5'd3, 7'b0010011));
        put(t, enc_r(7'd0, 5'd3, 5'd1, 3'b000, 5'd4));
        put(t, enc_s(12'd12, 5'd4, 5'd2, 3'b010));
        expect_st(t, 12, x1 + x3, 4'hF, "R5 add");
        put(t, enc_r(7'h20, 5'd3, 5'd1, 3'b000, 5'd6));
        put(t, enc_s(12'd16, 5'd6, 5'd2, 3'b010));
        expect_st(t, 16, x1 - x3, 4'hF, "R5 sub");
        put(t, enc_i({7'h20, 5'd1}, 5'd3, 3'b101, 5'd7, 7'b0010011));
        put(t, enc_s(12'd20, 5'd7, 5'd2, 3'b010));
        expect_st(t, 20, 32'hFFFF_FFFE, 4'hF, "R5 srai");
        put(t, enc_i(12'd4, 5'd3, 3'b101, 5'd8, 7'b0010011));
        put(t, enc_s(12'd24, 5'd8, 5'd2, 3'b010));
        expect_st(t, 24, 32'h0FFF_FFFF, 4'hF, "R5 srli");
        put(t, enc_r(7'd0, 5'd1, 5'd3, 3'b010, 5'd9));
        put(t, enc_s(12'd28, 5'd9, 5'd2, 3'b010));
        expect_st(t, 28, 32'd1, 4'hF, "R5 slt");
        put(t, enc_r(7'd0, 5'd1, 5'd3, 3'b011, 5'd10));
        put(t, enc_s(12'd32, 5'd10, 5'd2, 3'b010));
        expect_st(t, 32, 32'd0, 4'hF, "R5 sltu");
        put(t, enc_s(12'(36 + o), 5'd3, 5'd2, 3'b000));           // sb
        expect_st(t, 36, 32'hFDFD_FDFD, 4'(1 << o), "R7 byte store lane");
        put(t, enc_i(12'(36 + o), 5'd2, 3'b000, 5'd11, 7'b0000011));
        put(t, enc_s(12'd40, 5'd11, 5'd2, 3'b010));
        expect_st(t, 40, 32'hFFFF_FFFD, 4'hF, "R7 lb sign");
        put(t, enc_i(12'(36 + o), 5'd2, 3'b100, 5'd12, 7'b0000011));
        put(t, enc_s(12'd44, 5'd12, 5'd2, 3'b010));
        expect_st(t, 44, 32'h0000_00FD, 4'hF, "R7 lbu zero");
        put(t, enc_s(12'd50, 5'd3, 5'd2, 3'b001));                // sh upper half
        expect_st(t, 48, 32'hFFFD_FFFD, 4'b1100, "R7 half store lanes");
        put(t, enc_i(12'd50, 5'd2, 3'b001, 5'd13, 7'b0000011));
        put(t, enc_s(12'd52, 5'd13, 5'd2, 3'b010));
        expect_st(t, 52, 32'hFFFF_FFFD, 4'hF, "R7 lh sign");
        put(t, enc_i(12'd50, 5'd2, 3'b101, 5'd14, 7'b0000011));
        put(t, enc_s(12'd56, 5'd14, 5'd2, 3'b010));
        expect_st(t, 56, 32'h0000_FFFD, 4'hF, "R7 lhu zero");
        put(t, enc_b(13'd8, 5'd1, 5'd1, 3'b000));                 // beq taken
        put(t, enc_s(12'd60, 5'd3, 5'd2, 3'b010));                // skipped
        put(t, enc_b(13'd8, 5'd1, 5'd1, 3'b001));                 // bne not taken
        put(t, enc_i(12'd55, 5'd0, 3'b000, 5'd15, 7'b0010011));
        put(t, enc_s(12'd60, 5'd15, 5'd2, 3'b010));
        expect_st(t, 60, 32'd55, 4'hF, "R6 branch skip and fall-through");
        pcv = 32'(t*256 + ptr*4);
        put(t, enc_j(21'd8, 5'd16));                               // jal
        put(t, enc_s(12'd64, 5'd3, 5'd2, 3'b010));                // skipped
        put(t, enc_s(12'd64, 5'd16, 5'd2, 3'b010));
        expect_st(t, 64, pcv + 32'd4, 4'hF, "R6 jal link");
        pcv = 32'(t*256 + ptr*4);
        put(t, {20'h00000, 5'd17, 7'b0010111});                    // auipc
        put(t, enc_s(12'd68, 5'd17, 5'd2, 3'b010));
        expect_st(t, 68, pcv, 4'hF, "R5 auipc");
        put(t, enc_i(12'd17, 5'd17, 3'b000, 5'd18, 7'b1100111));  // jalr, odd target
        put(t, enc_s(12'd72, 5'd3, 5'd2, 3'b010));                // skipped
        put(t, enc_s(12'd72, 5'd18, 5'd2, 3'b010));
        expect_st(t, 72, pcv + 32'd12, 4'hF, "R6 jalr link");
        put(t, enc_r(7'd0, 5'd3, 5'd1, 3'b100, 5'd19));
        put(t, enc_s(12'd76, 5'd19, 5'd2, 3'b010));
        expect_st(t, 76, x1 ^ x3, 4'hF, "R5 xor");
        put(t, enc_j(21'd0, 5'd0));                                // park
    endtask

    // Main sequence: program, reset, rotation checks, then drain.
    initial begin
        for (int i = 0; i < 512; i++) imem[i] = 32'h0000_0013;
        for (int t = 0; t < NT; t++) begin
            start_pc[t*32 +: 32] = 32'(t*256);
            build_thread(t);
        end
        repeat (4) @(negedge clk);
        check("R8 no request in reset", {31'b0, dmem_req}, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            #1;
            check(k < 8 ? "R1 first-turn fetch address" : "R2 second-turn fetch address",
                  imem_addr, 32'((k % 8) * 256 + (k / 8) * 4));
            @(negedge clk);
        end
        repeat (600) @(negedge clk);
        for (int t = 0; t < NT; t++)
            check("R4 all expected stores seen", 32'(exp_q[t].size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule